// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a local transmit request and the enable of a single-wire bus driver. Its job is to stop a stuck-low transmit request from holding the bus dominant forever. The transmit input is synchronized into the block clock. A falling edge on the synchronized signal starts a low-time timer. If the input is still low after a programmable number of cycles, a fault is latched and the driver is forced recessive, which frees the bus for other nodes. The fault ends only when the input rises again. That rising edge also returns the timer to zero.

The guard acts only while the operating mode is normal and the disable input is clear. When the disable input is set, the driver simply follows the transmit request. The receive path is a plain pass-through from the bus level to the receive output. It keeps working during a fault, so the node still sees the traffic of its peers.

Top module: `tx_dom_guard`

## Requirements
- R1: During and right after reset, drv_en and fault are 0. The synchronizer flops reset to 1, which is recessive, so releasing reset never looks like a falling edge.
- R2: drv_en is 1 (drive dominant) exactly when mode_normal is 1, the twice-registered tx_in is 0, and no fault is latched. A change on tx_in reaches drv_en on the second rising clock edge after it is applied.
- R3: The timer is started only by a 1-to-0 transition of the synchronized input. If the input is already low when the guard becomes active (mode_normal rises or guard_off falls), no timeout occurs.
- R4: After a falling edge is detected while the guard is active, drv_en stays 1 for exactly TIMEOUT_CYCLES+1 cycles. It then drops to 0 as fault rises to 1, in the same cycle.
- R5: Once set, fault stays 1 and drv_en stays 0 for as long as the input stays low, no matter how long. The timer saturates and does not wrap.
- R6: A 0-to-1 transition of the synchronized input clears fault one cycle later. A following falling edge starts a full new timeout.
- R7: While mode_normal is 0, drv_en is 0. The cycle after mode_normal is seen low, the timer and fault are cleared.
- R8: While guard_off is 1, fault is cleared on the next cycle and never set, and drv_en follows the input without a time limit.
- R9: rx_out equals bus_rx at all times, including while fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_in | input | 1 | Asynchronous transmit request, 0 = dominant |
| bus_rx | input | 1 | Bus level from the receiver |
| mode_normal | input | 1 | 1 when the operating mode is normal |
| guard_off | input | 1 | Configuration bit, 1 bypasses the timeout |
| drv_en | output | 1 | 1 drives the bus dominant |
| rx_out | output | 1 | Receive output, follows bus_rx |
| fault | output | 1 | Registered timeout fault flag |

## Verification
A wrong synchronizer depth or a missed edge shows up at drv_en within two cycles of a tx_in change, as a misplaced dominant window. A timer that counts wrong, wraps, or starts on a level instead of an edge shows up as a fault at the wrong cycle. The bench checks this against an exact TIMEOUT_CYCLES+1 window, and with held-low periods several times longer than the limit. A fault latch that does not clear on a rising edge, a mode drop or the bypass bit leaves drv_en stuck at 0 one cycle after the clearing event.

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
  parameter int unsigned TIMEOUT_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in,
  input  logic bus_rx,
  input  logic mode_normal,
  input  logic guard_off,
  output logic drv_en,
  output logic rx_out,
  output logic fault
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYCLES);

  logic [2:0]    tx_sh;
  logic [CW-1:0] low_cnt;
  logic          running;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sh <= 3'b111;
    else        tx_sh <= {tx_sh[1:0], tx_in};

  wire tx_s  = tx_sh[1];
  wire tx_d  = tx_sh[2];
  wire fall  = tx_d & ~tx_s;
  wire rise  = ~tx_d & tx_s;
  wire armed = mode_normal & ~guard_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      low_cnt <= '0;
      fault   <= 1'b0;
    end else if (!armed || rise) begin
      running <= 1'b0;
      low_cnt <= '0;
      fault   <= 1'b0;
    end else if (fall) begin
      running <= 1'b1;
      low_cnt <= CW'(1);
      fault   <= 1'b0;
    end else if (running) begin
      if (low_cnt == LIM) fault   <= 1'b1;
      else                low_cnt <= low_cnt + 1'b1;
    end
  end

  assign drv_en = mode_normal & ~tx_s & ~fault;
  assign rx_out = bus_rx;
endmodule

// File: rtl/tx_dom_guard_chk.sv
module tx_dom_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rx,
  input logic mode_normal,
  input logic guard_off,
  input logic drv_en,
  input logic rx_out,
  input logic fault
);
  a_r5_fault_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !drv_en);
  a_r7_no_drive_outside_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_normal |-> !drv_en);
  a_r7_leave_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_normal |=> !fault);
  a_r8_bypass_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
    guard_off |=> !fault);
  a_r4_fault_follows_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(drv_en));
  a_r9_rx_live: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out == bus_rx);
endmodule

bind tx_dom_guard tx_dom_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .mode_normal(mode_normal),
  .guard_off(guard_off), .drv_en(drv_en), .rx_out(rx_out), .fault(fault)
);

// File: tb/test_tx_dom_guard.sv
module test_tx_dom_guard;
  localparam int unsigned LIM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in = 1'b1, bus_rx = 1'b1, mode_normal = 1'b1, guard_off = 1'b0;
  logic drv_en, rx_out, fault;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  bit m1, m2, m3, m_run, m_flt;
  int m_low;

  always #2 clk = ~clk;

  tx_dom_guard #(.TIMEOUT_CYCLES(LIM)) i_tx_dom_guard (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .bus_rx(bus_rx),
    .mode_normal(mode_normal), .guard_off(guard_off),
    .drv_en(drv_en), .rx_out(rx_out), .fault(fault)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 1; m2 = 1; m3 = 1; m_run = 0; m_flt = 0; m_low = 0;
    end else begin
      if (!(mode_normal && !guard_off) || (!m3 && m2)) begin
        m_run = 0; m_flt = 0; m_low = 0;
      end else if (m3 && !m2) begin
        m_run = 1; m_low = 1; m_flt = 0;
      end else if (m_run) begin
        if (m_low >= LIM) m_flt = 1;
        else m_low++;
      end
      m3 = m2; m2 = m1; m1 = tx_in;
    end
  end

  function automatic bit exp_drv();
    return mode_normal && !m2 && !m_flt;
  endfunction

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0d expected %0d", t, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    chk(tag, "drv_en", int'(drv_en), int'(exp_drv()));
    chk(tag, "fault", int'(fault), int'(m_flt));
    chk("R9", "rx_out", int'(rx_out), int'(bus_rx));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_0042));
    run(3);
    chk("R1", "drv_en in reset", int'(drv_en), 0);
    chk("R1", "fault in reset", int'(fault), 0);
    @(negedge clk); rst_n = 1'b1;
    run(4);
    chk("R1", "drv_en after reset", int'(drv_en), 0);

    tag = "R2";
    tx_in = 1'b0;
    step();
    chk("R2", "no drive after one edge", int'(drv_en), 0);
    step();
    chk("R2", "drive after two edges", int'(drv_en), 1);
    tx_in = 1'b1; run(4);

    tag = "R4";
    tx_in = 1'b0; cnt = 0;
    for (int i = 0; i < 3 * LIM; i++) begin step(); if (drv_en) cnt++; end
    chk("R4", "dominant window length", cnt, LIM + 1);
    chk("R4", "fault after window", int'(fault), 1);

    tag = "R5";
    run(5 * LIM);
    chk("R5", "fault held while low", int'(fault), 1);
    chk("R5", "drive held off", int'(drv_en), 0);

    tag = "R6";
    tx_in = 1'b1; run(4);
    chk("R6", "fault cleared by rise", int'(fault), 0);
    tx_in = 1'b0; cnt = 0;
    for (int i = 0; i < 3 * LIM; i++) begin step(); if (drv_en) cnt++; end
    chk("R6", "full new window", cnt, LIM + 1);

    tag = "R7";
    mode_normal = 1'b0; run(3);
    chk("R7", "fault cleared leaving normal", int'(fault), 0);
    chk("R7", "no drive outside normal", int'(drv_en), 0);

    tag = "R3";
    mode_normal = 1'b1; run(4 * LIM);
    chk("R3", "no timeout without edge", int'(fault), 0);
    chk("R3", "low input still drives", int'(drv_en), 1);
    tx_in = 1'b1; run(4);

    tag = "R8";
    guard_off = 1'b1; tx_in = 1'b0; run(4 * LIM);
    chk("R8", "bypass never faults", int'(fault), 0);
    chk("R8", "bypass keeps drive", int'(drv_en), 1);
    guard_off = 1'b0; tx_in = 1'b1; run(3);
    tx_in = 1'b0; run(LIM + 6);
    guard_off = 1'b1; run(2);
    chk("R8", "bypass clears fault", int'(fault), 0);
    guard_off = 1'b0; tx_in = 1'b1; run(4);

    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) tx_in = ~tx_in;
      if ($urandom_range(0, 2) == 0) bus_rx = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) mode_normal = ~mode_normal;
      if ($urandom_range(0, 299) == 0) guard_off = ~guard_off;
      step();
    end
    finish_run();
  end
endmodule